// File: doc/BRIEF.md
# Dependence-Steered Cluster Selector

This block picks the issue-queue cluster for one instruction per cycle in a clustered out-of-order core. It keeps a table with one entry for each thread and architectural register. An entry holds the cluster that will produce the register, a predicted ready time, a pending-producer mark and a chained mark. The instruction goes to the cluster of whichever source is still waiting on a producer and is predicted ready last. If no source waits on a producer, the instruction goes to the queue with the fewest occupied entries.

The chosen queue reports two things: whether it is full, and whether it has no bandwidth this cycle. If the preferred queue refuses only because it has no bandwidth, the block checks the least-full queue and moves the instruction there if that queue can take it. When an instruction is dispatched, the cluster it actually went to is written into the entry of its destination register. Another scheduling stage supplies the pending mark, the chained mark and the predicted ready times through a producer-note port.

The selection is combinational from the inputs and the table. Table writes take effect at the next clock edge.

Top module: `dep_cluster_sel`

## Requirements
- R1: After reset every table entry has no pending producer, so every source is treated as ready. While `in_valid` is low, `disp_valid` is 0 and `disp_cause` is 0.
- R2: If no valid source has a pending producer, `sel_dep` is 0 and `pref_cluster` is the queue with the smallest `q_occ` count. A tie goes to the lowest queue index.
- R3: Among the valid sources with a pending producer, `sel_dep` is 1 and `pref_cluster` is the recorded cluster of the source with the strictly larger predicted ready time. A tie goes to source 0. A source whose valid bit is low is ignored.
- R4: If the preferred queue is neither full nor out of bandwidth, `disp_valid` is 1, `disp_cluster` equals `pref_cluster` and `disp_cause` is 0.
- R5: If the preferred queue is full, the instruction is refused whatever its bandwidth: `disp_valid` is 0 and `disp_cause` is 1.
- R6: If the preferred queue is out of bandwidth but not full, the instruction goes to the least-full queue if that queue accepts, with `disp_cause` 0. Otherwise it is refused with `disp_cause` 2, even when the least-full queue refused for being full.
- R7: A dispatch with `dst_valid` high writes `disp_cluster` into the entry for (`in_tid`, `dst_reg`). An instruction in the very next cycle sees the new value. A refused instruction, or one with `dst_valid` low, leaves the table unchanged. A producer note sets the pending mark, the chained mark and the ready time of an entry, but not its cluster.
- R8: `sel_chained` gives the chained mark of the winning source and is 0 whenever `sel_dep` is 0. A producer note with the pending mark low must not carry the chained mark.
- R9: Each thread has its own entries: a write for one thread never affects the same register number in another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| prod_we | input | 1 | Producer note write enable |
| prod_tid | input | TID_W | Thread of the producer note |
| prod_reg | input | REG_W | Register of the producer note |
| prod_pending | input | 1 | Register still waits on a producer |
| prod_chained | input | 1 | Register producer is chained |
| prod_ready | input | RT_W | Predicted ready time |
| in_valid | input | 1 | Instruction present |
| in_tid | input | TID_W | Instruction thread |
| src0_valid | input | 1 | Source 0 used |
| src0_reg | input | REG_W | Source 0 register |
| src1_valid | input | 1 | Source 1 used |
| src1_reg | input | REG_W | Source 1 register |
| dst_valid | input | 1 | Instruction writes a destination |
| dst_reg | input | REG_W | Destination register |
| q_occ | input | NQ*OCC_W | Occupancy count per queue, queue i at bits [i*OCC_W +: OCC_W] |
| q_full | input | NQ | Queue refuses for lack of entries |
| q_nobw | input | NQ | Queue refuses for lack of bandwidth |
| disp_valid | output | 1 | Instruction dispatched this cycle |
| disp_cluster | output | QID_W | Queue used; meaningful only with disp_valid |
| disp_cause | output | 2 | 0 none, 1 preferred full, 2 bandwidth |
| pref_cluster | output | QID_W | Preferred queue before the bandwidth retry |
| sel_dep | output | 1 | Preference came from a pending producer |
| sel_chained | output | 1 | Chained mark of the winning source |

## Verification
The bench uses the default build: two threads, 32 registers per thread, four queues, 5-bit occupancy counts and 8-bit ready times. With four queues, the bench can set up occupancy ties, preferred and fallback queues that are distinct, and the case where the preferred queue is itself the least-full queue. With two threads, it can check that entries of one thread are isolated from the other. Because the ready times are 8 bits wide, the bench can set up equal and unequal ready times to cover both the tie rule and the strictly-larger rule.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_FULL = 2'd1,
    CAUSE_BW   = 2'd2
  } cause_e;

  localparam int unsigned NSRC = 2;
endpackage

// File: rtl/cds_table.sv
module cds_table #(
  parameter int unsigned THREADS = 2,
  parameter int unsigned REGS    = 32,
  parameter int unsigned NQ      = 4,
  parameter int unsigned RT_W    = 8,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned REG_W  = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int unsigned QID_W  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int unsigned NSRC   = cds_pkg::NSRC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prod_we,
  input  logic [TID_W-1:0]            prod_tid,
  input  logic [REG_W-1:0]            prod_reg,
  input  logic                        prod_pending,
  input  logic                        prod_chained,
  input  logic [RT_W-1:0]             prod_ready,
  input  logic                        clu_we,
  input  logic [TID_W-1:0]            clu_tid,
  input  logic [REG_W-1:0]            clu_reg,
  input  logic [QID_W-1:0]            clu_val,
  input  logic [TID_W-1:0]            rd_tid,
  input  logic [NSRC-1:0][REG_W-1:0]  rd_reg,
  output logic [NSRC-1:0]             rd_pend,
  output logic [NSRC-1:0]             rd_chn,
  output logic [NSRC-1:0][RT_W-1:0]   rd_rdy,
  output logic [NSRC-1:0][QID_W-1:0]  rd_clu
);
  localparam int unsigned ENTRIES = THREADS * REGS;

  logic             pend_q [ENTRIES];
  logic             chn_q  [ENTRIES];
  logic [RT_W-1:0]  rdy_q  [ENTRIES];
  logic [QID_W-1:0] clu_q  [ENTRIES];

  int unsigned pidx, cidx;
  logic        pwr_en, cwr_en;

  always_comb begin
    pidx   = int'(prod_tid) * REGS + int'(prod_reg);
    cidx   = int'(clu_tid) * REGS + int'(clu_reg);
    pwr_en = prod_we && (pidx < ENTRIES);
    cwr_en = clu_we && (cidx < ENTRIES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        pend_q[e] <= 1'b0;
        chn_q[e]  <= 1'b0;
        rdy_q[e]  <= '0;
        clu_q[e]  <= '0;
      end
    end else begin
      if (pwr_en) begin
        pend_q[pidx] <= prod_pending;
        chn_q[pidx]  <= prod_chained;
        rdy_q[pidx]  <= prod_ready;
      end
      if (cwr_en) begin
        clu_q[cidx] <= clu_val;
      end
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_rd
    int unsigned ridx;
    always_comb begin
      ridx = int'(rd_tid) * REGS + int'(rd_reg[k]);
      if (ridx < ENTRIES) begin
        rd_pend[k] = pend_q[ridx];
        rd_chn[k]  = chn_q[ridx];
        rd_rdy[k]  = rdy_q[ridx];
        rd_clu[k]  = clu_q[ridx];
      end else begin
        rd_pend[k] = 1'b0;
        rd_chn[k]  = 1'b0;
        rd_rdy[k]  = '0;
        rd_clu[k]  = '0;
      end
    end
  end
endmodule

// File: rtl/cds_least_full.sv
module cds_least_full #(
  parameter int unsigned NQ    = 4,
  parameter int unsigned OCC_W = 5,
  localparam int unsigned QID_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ*OCC_W-1:0] occ,
  output logic [QID_W-1:0]    lf_idx
);
  logic [OCC_W-1:0] best_occ;

  always_comb begin
    lf_idx   = '0;
    best_occ = occ[0 +: OCC_W];
    for (int i = 1; i < NQ; i++) begin
      if (occ[i*OCC_W +: OCC_W] < best_occ) begin
        best_occ = occ[i*OCC_W +: OCC_W];
        lf_idx   = QID_W'(i);
      end
    end
  end
endmodule

// File: rtl/cds_steer.sv
module cds_steer #(
  parameter int unsigned NQ   = 4,
  parameter int unsigned RT_W = 8,
  localparam int unsigned QID_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int unsigned NSRC  = cds_pkg::NSRC
) (
  input  logic [NSRC-1:0]            src_v,
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0]            chn,
  input  logic [NSRC-1:0][RT_W-1:0]  rdy,
  input  logic [NSRC-1:0][QID_W-1:0] clu,
  input  logic [QID_W-1:0]           lf_idx,
  output logic                       dep,
  output logic [QID_W-1:0]           pref,
  output logic                       chained
);
  logic [RT_W-1:0] best_rdy;

  always_comb begin
    dep      = 1'b0;
    pref     = lf_idx;
    chained  = 1'b0;
    best_rdy = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (src_v[k] && pend[k] && (!dep || (rdy[k] > best_rdy))) begin
        dep      = 1'b1;
        pref     = clu[k];
        chained  = chn[k];
        best_rdy = rdy[k];
      end
    end
  end
endmodule

// File: rtl/dep_cluster_sel.sv
module dep_cluster_sel #(
  parameter int unsigned THREADS = 2,
  parameter int unsigned REGS    = 32,
  parameter int unsigned NQ      = 4,
  parameter int unsigned OCC_W   = 5,
  parameter int unsigned RT_W    = 8,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned REG_W  = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int unsigned QID_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prod_we,
  input  logic [TID_W-1:0]    prod_tid,
  input  logic [REG_W-1:0]    prod_reg,
  input  logic                prod_pending,
  input  logic                prod_chained,
  input  logic [RT_W-1:0]     prod_ready,
  input  logic                in_valid,
  input  logic [TID_W-1:0]    in_tid,
  input  logic                src0_valid,
  input  logic [REG_W-1:0]    src0_reg,
  input  logic                src1_valid,
  input  logic [REG_W-1:0]    src1_reg,
  input  logic                dst_valid,
  input  logic [REG_W-1:0]    dst_reg,
  input  logic [NQ*OCC_W-1:0] q_occ,
  input  logic [NQ-1:0]       q_full,
  input  logic [NQ-1:0]       q_nobw,
  output logic                disp_valid,
  output logic [QID_W-1:0]    disp_cluster,
  output logic [1:0]          disp_cause,
  output logic [QID_W-1:0]    pref_cluster,
  output logic                sel_dep,
  output logic                sel_chained
);
  import cds_pkg::*;

  logic [NSRC-1:0]            rd_pend, rd_chn, src_v;
  logic [NSRC-1:0][RT_W-1:0]  rd_rdy;
  logic [NSRC-1:0][QID_W-1:0] rd_clu;
  logic [NSRC-1:0][REG_W-1:0] rd_reg;
  logic [QID_W-1:0]           lf_idx, pref;
  logic                       dep, chained;
  logic                       pref_ok, lf_ok, wr_en;
  cause_e                     cause;

  assign rd_reg = {src1_reg, src0_reg};
  assign src_v  = {src1_valid, src0_valid};

  cds_table #(
    .THREADS(THREADS), .REGS(REGS), .NQ(NQ), .RT_W(RT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .prod_we(prod_we), .prod_tid(prod_tid), .prod_reg(prod_reg),
    .prod_pending(prod_pending), .prod_chained(prod_chained),
    .prod_ready(prod_ready),
    .clu_we(wr_en), .clu_tid(in_tid), .clu_reg(dst_reg),
    .clu_val(disp_cluster),
    .rd_tid(in_tid), .rd_reg(rd_reg),
    .rd_pend(rd_pend), .rd_chn(rd_chn), .rd_rdy(rd_rdy), .rd_clu(rd_clu)
  );

  cds_least_full #(.NQ(NQ), .OCC_W(OCC_W)) u_lf (
    .occ(q_occ), .lf_idx(lf_idx)
  );

  cds_steer #(.NQ(NQ), .RT_W(RT_W)) u_steer (
    .src_v(src_v), .pend(rd_pend), .chn(rd_chn), .rdy(rd_rdy),
    .clu(rd_clu), .lf_idx(lf_idx),
    .dep(dep), .pref(pref), .chained(chained)
  );

  always_comb begin
    pref_ok      = !q_full[pref] && !q_nobw[pref];
    lf_ok        = !q_full[lf_idx] && !q_nobw[lf_idx];
    disp_valid   = 1'b0;
    disp_cluster = pref;
    cause        = CAUSE_NONE;
    if (in_valid) begin
      if (pref_ok) begin
        disp_valid = 1'b1;
      end else if (q_full[pref]) begin
        cause = CAUSE_FULL;
      end else if (lf_ok) begin
        disp_valid   = 1'b1;
        disp_cluster = lf_idx;
      end else begin
        cause = CAUSE_BW;
      end
    end
    wr_en = disp_valid && dst_valid;
  end

  assign disp_cause   = cause;
  assign pref_cluster = pref;
  assign sel_dep      = in_valid && dep;
  assign sel_chained  = in_valid && dep && chained;
endmodule

// File: rtl/dep_cluster_sel_chk.sv
module dep_cluster_sel_chk #(
  parameter int unsigned THREADS = 2,
  parameter int unsigned REGS    = 32,
  parameter int unsigned NQ      = 4,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned REG_W  = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int unsigned QID_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prod_we,
  input logic             prod_pending,
  input logic             prod_chained,
  input logic             in_valid,
  input logic [TID_W-1:0] in_tid,
  input logic             src0_valid,
  input logic [REG_W-1:0] src0_reg,
  input logic             src1_valid,
  input logic             dst_valid,
  input logic [REG_W-1:0] dst_reg,
  input logic [NQ-1:0]    q_full,
  input logic [NQ-1:0]    q_nobw,
  input logic             disp_valid,
  input logic [QID_W-1:0] disp_cluster,
  input logic [1:0]       disp_cause,
  input logic [QID_W-1:0] pref_cluster,
  input logic             sel_dep,
  input logic             sel_chained
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!disp_valid && disp_cause == 2'd0));

  assert_target_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (!q_full[disp_cluster] && !q_nobw[disp_cluster]));

  assert_full_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && q_full[pref_cluster]) |-> (!disp_valid && disp_cause == 2'd1));

  assert_move_only_bw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_cluster != pref_cluster) |->
      (q_nobw[pref_cluster] && !q_full[pref_cluster]));

  assert_refusal_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !disp_valid) |-> (disp_cause != 2'd0));

  assert_chain_needs_dep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_dep |-> !sel_chained);

  assert_note_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_we && !prod_pending) |-> !prod_chained);

  assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && in_valid && src0_valid && !src1_valid && sel_dep &&
     $past(disp_valid && dst_valid) && in_tid == $past(in_tid) &&
     src0_reg == $past(dst_reg)) |-> (pref_cluster == $past(disp_cluster)));
endmodule

bind dep_cluster_sel dep_cluster_sel_chk #(
  .THREADS(THREADS), .REGS(REGS), .NQ(NQ)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .prod_we(prod_we), .prod_pending(prod_pending), .prod_chained(prod_chained),
  .in_valid(in_valid), .in_tid(in_tid),
  .src0_valid(src0_valid), .src0_reg(src0_reg), .src1_valid(src1_valid),
  .dst_valid(dst_valid), .dst_reg(dst_reg),
  .q_full(q_full), .q_nobw(q_nobw),
  .disp_valid(disp_valid), .disp_cluster(disp_cluster), .disp_cause(disp_cause),
  .pref_cluster(pref_cluster), .sel_dep(sel_dep), .sel_chained(sel_chained)
);

// File: tb/dep_cluster_sel_bench.sv
`timescale 1ns/1ps
module dep_cluster_sel_bench;
  localparam int T = 2, R = 32, NQ = 4, OW = 5, RW = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic prod_we, prod_pending, prod_chained;
  logic [0:0] prod_tid, in_tid;
  logic [4:0] prod_reg, src0_reg, src1_reg, dst_reg;
  logic [RW-1:0] prod_ready;
  logic in_valid, src0_valid, src1_valid, dst_valid;
  logic [NQ*OW-1:0] q_occ;
  logic [NQ-1:0] q_full, q_nobw;
  logic disp_valid, sel_dep, sel_chained;
  logic [1:0] disp_cluster, pref_cluster, disp_cause;

  dep_cluster_sel u_dep_cluster_sel (.*);

  int occ [NQ];
  bit qf [NQ];
  bit qn [NQ];
  bit m_pend [T][R];
  bit m_chn  [T][R];
  int m_rdy  [T][R];
  int m_clu  [T][R];

  typedef struct {
    bit    v;
    int    clu;
    int    cause;
    int    pref;
    bit    dep;
    bit    chn;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic drive_queues();
    for (int i = 0; i < NQ; i++) begin
      q_occ[i*OW +: OW] = OW'(occ[i]);
      q_full[i] = qf[i];
      q_nobw[i] = qn[i];
    end
  endtask

  function automatic int least_full();
    int b = 0;
    for (int i = 1; i < NQ; i++) if (occ[i] < occ[b]) b = i;
    return b;
  endfunction

  task automatic set_q(input int o0, o1, o2, o3);
    occ[0] = o0; occ[1] = o1; occ[2] = o2; occ[3] = o3;
    for (int i = 0; i < NQ; i++) begin qf[i] = 0; qn[i] = 0; end
  endtask

  task automatic note(input int t, input int r, input bit p, input bit c, input int rdy);
    @(negedge clk);
    in_valid = 0; prod_we = 1; prod_tid = 1'(t); prod_reg = 5'(r);
    prod_pending = p; prod_chained = c; prod_ready = RW'(rdy);
    m_pend[t][r] = p; m_chn[t][r] = c; m_rdy[t][r] = rdy;
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    prod_we = 0; in_valid = 0;
    e.v = 0; e.clu = 0; e.cause = 0; e.pref = -1; e.dep = 0; e.chn = 0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic issue(input int t, input bit s0v, input int s0, input bit s1v,
                       input int s1, input bit dv, input int d, input string tag);
    exp_t e;
    int lf, best;
    @(negedge clk);
    prod_we = 0; in_valid = 1; in_tid = 1'(t);
    src0_valid = s0v; src0_reg = 5'(s0); src1_valid = s1v; src1_reg = 5'(s1);
    dst_valid = dv; dst_reg = 5'(d);
    drive_queues();
    lf = least_full();
    e.dep = 0; e.chn = 0; e.pref = lf; best = 0;
    if (s0v && m_pend[t][s0]) begin
      e.dep = 1; e.pref = m_clu[t][s0]; e.chn = m_chn[t][s0]; best = m_rdy[t][s0];
    end
    if (s1v && m_pend[t][s1] && (!e.dep || m_rdy[t][s1] > best)) begin
      e.dep = 1; e.pref = m_clu[t][s1]; e.chn = m_chn[t][s1];
    end
    e.v = 0; e.cause = 0; e.clu = e.pref;
    if (!qf[e.pref] && !qn[e.pref]) e.v = 1;
    else if (qf[e.pref]) e.cause = 1;
    else if (!qf[lf] && !qn[lf]) begin e.v = 1; e.clu = lf; end
    else e.cause = 2;
    e.tag = tag;
    exp_q.push_back(e);
    if (e.v && dv) m_clu[t][d] = e.clu;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tests++;
        if (disp_valid !== e.v || disp_cause !== 2'(e.cause) ||
            (e.v && disp_cluster !== 2'(e.clu)) ||
            (e.pref >= 0 && pref_cluster !== 2'(e.pref)) ||
            sel_dep !== e.dep || sel_chained !== e.chn) begin
          fails++;
          $display("FAIL %s: got v=%0d clu=%0d cause=%0d pref=%0d dep=%0d chn=%0d exp v=%0d clu=%0d cause=%0d pref=%0d dep=%0d chn=%0d",
                   e.tag, disp_valid, disp_cluster, disp_cause, pref_cluster, sel_dep,
                   sel_chained, e.v, e.clu, e.cause, e.pref, e.dep, e.chn);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 0; prod_we = 0; prod_tid = 0; prod_reg = 0; prod_pending = 0;
    prod_chained = 0; prod_ready = 0; in_valid = 0; in_tid = 0;
    src0_valid = 0; src0_reg = 0; src1_valid = 0; src1_reg = 0;
    dst_valid = 0; dst_reg = 0;
    for (int t = 0; t < T; t++)
      for (int r = 0; r < R; r++) begin
        m_pend[t][r] = 0; m_chn[t][r] = 0; m_rdy[t][r] = 0; m_clu[t][r] = 0;
      end
    set_q(0, 0, 0, 0);
    drive_queues();
    repeat (3) @(negedge clk);
    rst_n = 1;

    idle("R1 idle after reset");
    set_q(5, 3, 3, 7);
    issue(0, 1, 4, 1, 6, 0, 0, "R1 sources ready after reset, R2 tie to lower index");
    issue(0, 0, 0, 0, 0, 1, 4, "R2 R4 least-full q1, record r4");
    set_q(9, 9, 9, 1);
    issue(0, 0, 0, 0, 0, 1, 6, "R2 R4 least-full q3, record r6");
    note(0, 4, 1, 0, 10);
    note(0, 6, 1, 0, 20);
    set_q(0, 9, 9, 9);
    issue(0, 1, 4, 1, 6, 0, 0, "R3 later source 1 wins");
    issue(0, 1, 6, 1, 4, 0, 0, "R3 later source 0 wins");
    note(0, 6, 1, 0, 10);
    issue(0, 1, 4, 1, 6, 0, 0, "R3 tie goes to source 0 (r4)");
    issue(0, 1, 6, 1, 4, 0, 0, "R3 tie goes to source 0 (r6)");
    issue(0, 1, 4, 0, 6, 0, 0, "R3 invalid source 1 ignored");
    issue(0, 0, 6, 1, 4, 0, 0, "R3 invalid source 0 ignored");
    issue(1, 1, 4, 1, 6, 0, 0, "R9 other thread has no pending producer");

    note(0, 8, 1, 0, 30);
    set_q(9, 9, 0, 9);
    issue(0, 0, 0, 0, 0, 1, 8, "R7 dispatch records r8 to q2");
    set_q(0, 9, 9, 9);
    issue(0, 1, 8, 0, 0, 0, 0, "R7 next cycle sees q2");
    qf[2] = 1; qn[2] = 1;
    issue(0, 1, 8, 0, 0, 1, 8, "R5 preferred full refuses");
    qf[2] = 0; qn[2] = 0;
    issue(0, 1, 8, 0, 0, 0, 0, "R7 refused dispatch left r8 unchanged");
    issue(0, 1, 8, 0, 0, 0, 8, "R7 dst_valid low, no write");
    issue(0, 1, 8, 0, 0, 0, 0, "R7 r8 still q2");

    qn[2] = 1;
    issue(0, 1, 8, 0, 0, 1, 8, "R6 bandwidth retry moves to q0 and records");
    qn[2] = 0;
    issue(0, 1, 8, 0, 0, 0, 0, "R6 R7 r8 now in q0");
    issue(1, 0, 0, 1, 8, 0, 0, "R9 thread 1 r8 untouched");
    set_q(9, 9, 9, 0);
    qn[0] = 1; qf[3] = 1;
    issue(0, 1, 8, 0, 0, 0, 0, "R6 fallback full reports bandwidth");
    set_q(0, 9, 9, 9);
    qn[0] = 1;
    issue(0, 1, 8, 0, 0, 0, 0, "R6 preferred equals least-full");

    note(0, 10, 1, 1, 50);
    set_q(0, 9, 9, 9);
    issue(0, 1, 10, 1, 4, 0, 0, "R8 chained mark of winner");
    issue(0, 1, 4, 1, 10, 0, 0, "R8 chained from source 1");
    note(0, 10, 0, 0, 50);
    issue(0, 1, 10, 0, 0, 0, 0, "R8 no pending clears chained");
    idle("R1 idle at end");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule